// File: doc/BRIEF.md
# Dual-Modulus Prescaler Swallow Controller

This block sits behind an external dual-modulus prescaler and turns that prescaler's output pulses into the divided feedback strobe of a frequency synthesizer. It also drives the modulus-control line that selects the prescaler's ratio. Each prescaler output pulse arrives as a one-clock `pulse_en` on the block's clock. A count cycle always spans N counted pulses. For the first A of them the control line is low, which selects ratio P+1. For the remaining N−A pulses it is high, which selects ratio P. One full cycle therefore divides the synthesizer output by N·P + A.

Two programmed values come in on parallel inputs: the total count N and the swallow count A. The block samples them only when it reloads its counters, so software may rewrite them at any time without breaking the cycle in progress. A registered flag reports when the programmed pair cannot produce a valid cycle.

Top module: `dm_swallow_div`

## Requirements
- R1: While reset is asserted, `mod_ctl`, `fv_strobe` and `cfg_bad` are all 0.
- R2: When the N counter is empty, the next clock loads `n_value` and `a_value` and ignores any `pulse_en` in that clock. The N counter is empty after reset and after a reload of N = 0. After reset with pulses present on every clock, the first strobe therefore appears N+1 clocks after reset release.
- R3: After a reload with A > 0, `mod_ctl` is 0 for exactly the first A counted pulses of the cycle and then rises. It rises only after a counted pulse or a load.
- R4: Each cycle counts exactly N pulses. Of these, N−A are counted with `mod_ctl` at 1, so the total division is N·P + A.
- R5: `fv_strobe` is 1 for one clock, in the clock after the pulse that completes the N count, and at no other time.
- R6: The completing pulse reloads both counters from the current inputs. `mod_ctl` falls only together with `fv_strobe`.
- R7: A change of `n_value` or `a_value` during a cycle does not alter the length or the control pattern of that cycle. The new values take effect at the next reload.
- R8: With A = 0, `mod_ctl` is 1 for every pulse of the cycle. With A = N it is 0 for every pulse.
- R9: `cfg_bad` is 1 one clock after the inputs show N = 0 or A > N, and 0 one clock after they show 1 ≤ N and A ≤ N.
- R10: A clock without `pulse_en` leaves the counters unchanged. In the next clock `mod_ctl` is unchanged and `fv_strobe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_en | input | 1 | One prescaler output pulse, one clock wide |
| n_value | input | N_W | Programmed total count N |
| a_value | input | A_W | Programmed swallow count A |
| mod_ctl | output | 1 | Modulus control: 0 selects P+1, 1 selects P |
| fv_strobe | output | 1 | One-clock strobe at the end of each count cycle |
| cfg_bad | output | 1 | Programmed pair violates 1 ≤ N and A ≤ N |

## Verification
On every clock, the in-line properties check the local timing rules. They confirm that a strobe always follows a pulse and that the control line falls only with a strobe. They confirm that it rises only after a counted pulse or a load, that an idle clock freezes the control line and suppresses the strobe, and that a running counter steps down by exactly one. Whole-cycle properties can only be shown by the bench's scenarios: the split of A low and N−A high pulses, deferral of mid-cycle value changes to the reload, the A = 0, A = N and N = 1 boundaries, and the reload-then-ignore behaviour after reset. The bench compares each of these against its behavioural model on every clock.

// File: rtl/dm_swallow_pkg.sv
package dm_swallow_pkg;

   // Command to one down-counter: load from the programmed value, or step down by one.
   typedef struct packed {
      logic load;
      logic dec;
   } cnt_cmd_t;

   // Counter behaviour when asked to step below zero.
   typedef enum logic [0:0] {
      CNT_HOLD_AT_ZERO = 1'b0,
      CNT_WRAP         = 1'b1
   } cnt_floor_e;

endpackage

// File: rtl/dm_dncount.sv
module dm_dncount
   import dm_swallow_pkg::*;
#(
   parameter int         W     = 8,
   parameter cnt_floor_e FLOOR = CNT_HOLD_AT_ZERO
) (
   input  logic         clk,
   input  logic         rst_n,
   input  cnt_cmd_t     cmd,
   input  logic [W-1:0] load_val,
   output logic         is_zero,
   output logic         is_one
);

   localparam logic [W-1:0] ZERO = '0;
   localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

   generate
      if (W < 1) begin : g_bad_width
         $error("dm_dncount: W must be at least 1");
      end
   endgenerate

   logic [W-1:0] cnt_q;
   logic [W-1:0] step_val;

   generate
      if (FLOOR == CNT_HOLD_AT_ZERO) begin : g_floor
         assign step_val = (cnt_q == ZERO) ? ZERO : cnt_q - ONE;
      end else begin : g_wrap
         assign step_val = cnt_q - ONE;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= ZERO;
      end else if (cmd.load) begin
         cnt_q <= load_val;
      end else if (cmd.dec) begin
         cnt_q <= step_val;
      end
   end

   assign is_zero = (cnt_q == ZERO);
   assign is_one  = (cnt_q == ONE);

   // R4
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd.dec && !cmd.load && (cnt_q != ZERO)) |=> (cnt_q == $past(cnt_q) - ONE));

endmodule

// File: rtl/dm_cfg_check.sv
module dm_cfg_check #(
   parameter int N_W = 10,
   parameter int A_W = 7
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [N_W-1:0] n_value,
   input  logic [A_W-1:0] a_value,
   output logic           cfg_bad
);

   localparam int CW = (N_W > A_W) ? N_W : A_W;

   logic [CW-1:0] n_ext;
   logic [CW-1:0] a_ext;

   generate
      if (N_W == CW) begin : g_n_wide
         assign n_ext = n_value;
      end else begin : g_n_pad
         assign n_ext = {{(CW-N_W){1'b0}}, n_value};
      end
      if (A_W == CW) begin : g_a_wide
         assign a_ext = a_value;
      end else begin : g_a_pad
         assign a_ext = {{(CW-A_W){1'b0}}, a_value};
      end
   endgenerate

   logic bad_now;
   assign bad_now = (n_ext == '0) || (a_ext > n_ext);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_bad <= 1'b0;
      end else begin
         cfg_bad <= bad_now;
      end
   end

endmodule

// File: rtl/dm_swallow_seq.sv
module dm_swallow_seq
   import dm_swallow_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     pulse_en,
   input  logic     n_zero,
   input  logic     n_one,
   input  logic     a_zero,
   output cnt_cmd_t n_cmd,
   output cnt_cmd_t a_cmd,
   output logic     mod_ctl,
   output logic     fv_strobe
);

   logic reload;
   logic finish;

   // The completing pulse and the empty-counter case both reload.
   assign finish = pulse_en && n_one;
   assign reload = n_zero || finish;

   assign n_cmd.load = reload;
   assign n_cmd.dec  = pulse_en && !reload;
   assign a_cmd.load = reload;
   assign a_cmd.dec  = pulse_en && !reload && !a_zero;

   // High once the swallow count is spent, while a cycle is loaded.
   assign mod_ctl = !n_zero && a_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fv_strobe <= 1'b0;
      end else begin
         fv_strobe <= finish;
      end
   end

   // R5
   strobe_after_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fv_strobe |-> $past(pulse_en));

   // R6
   mc_fall_with_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mod_ctl) |-> fv_strobe);

   // R3
   mc_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mod_ctl) |-> ($past(pulse_en) || $past(n_zero)));

   // R10
   idle_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pulse_en && !n_zero) |=> ($stable(mod_ctl) && !fv_strobe));

endmodule

// File: rtl/dm_swallow_div.sv
module dm_swallow_div
   import dm_swallow_pkg::*;
#(
   parameter int N_W = 10,
   parameter int A_W = 7
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           pulse_en,
   input  logic [N_W-1:0] n_value,
   input  logic [A_W-1:0] a_value,
   output logic           mod_ctl,
   output logic           fv_strobe,
   output logic           cfg_bad
);

   generate
      if (N_W < 2) begin : g_bad_nw
         $error("dm_swallow_div: N_W must be at least 2");
      end
      if (A_W < 1) begin : g_bad_aw
         $error("dm_swallow_div: A_W must be at least 1");
      end
   endgenerate

   cnt_cmd_t n_cmd;
   cnt_cmd_t a_cmd;
   logic     n_zero;
   logic     n_one;
   logic     a_zero;
   logic     a_one;

   dm_dncount #(.W(N_W), .FLOOR(CNT_HOLD_AT_ZERO)) u_n_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd      (n_cmd),
      .load_val (n_value),
      .is_zero  (n_zero),
      .is_one   (n_one)
   );

   dm_dncount #(.W(A_W), .FLOOR(CNT_HOLD_AT_ZERO)) u_a_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd      (a_cmd),
      .load_val (a_value),
      .is_zero  (a_zero),
      .is_one   (a_one)
   );

   dm_swallow_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .pulse_en  (pulse_en),
      .n_zero    (n_zero),
      .n_one     (n_one),
      .a_zero    (a_zero),
      .n_cmd     (n_cmd),
      .a_cmd     (a_cmd),
      .mod_ctl   (mod_ctl),
      .fv_strobe (fv_strobe)
   );

   dm_cfg_check #(.N_W(N_W), .A_W(A_W)) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .n_value (n_value),
      .a_value (a_value),
      .cfg_bad (cfg_bad)
   );

   // R3
   last_swallow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (a_one && a_cmd.dec) |=> mod_ctl);

endmodule

// File: tb/test_dm_swallow_div.sv
module test_dm_swallow_div;

   localparam int CLK_PERIOD = 10;
   localparam int NW = 10;
   localparam int AW = 7;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pulse_en = 1'b0;
   logic [NW-1:0] n_value = '0;
   logic [AW-1:0] a_value = '0;
   logic          mod_ctl;
   logic          fv_strobe;
   logic          cfg_bad;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit cmp_en = 1'b0;
   string cur_req = "R1";

   always #(CLK_PERIOD/2) clk = ~clk;

   dm_swallow_div #(.N_W(NW), .A_W(AW)) i_dm_swallow_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .pulse_en  (pulse_en),
      .n_value   (n_value),
      .a_value   (a_value),
      .mod_ctl   (mod_ctl),
      .fv_strobe (fv_strobe),
      .cfg_bad   (cfg_bad)
   );

   // Behavioural reference: remaining pulses in the cycle, remaining low pulses.
   int m_left = 0;
   int m_low  = 0;
   bit m_str  = 0;
   bit m_bad  = 0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_left <= 0; m_low <= 0; m_str <= 0; m_bad <= 0;
      end else begin
         m_bad <= (int'(n_value) == 0) || (int'(a_value) > int'(n_value));
         m_str <= 0;
         if (m_left == 0) begin
            m_left <= int'(n_value);
            m_low  <= int'(a_value);
         end else if (pulse_en) begin
            if (m_left == 1) begin
               m_left <= int'(n_value);
               m_low  <= int'(a_value);
               m_str  <= 1;
            end else begin
               m_left <= m_left - 1;
               if (m_low > 0) m_low <= m_low - 1;
            end
         end
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      cycles++;
      if (cmp_en) begin
         check(mod_ctl == ((m_left != 0) && (m_low == 0)), cur_req, "mod_ctl vs model",
               int'(mod_ctl), int'((m_left != 0) && (m_low == 0)));
         check(fv_strobe == m_str, cur_req, "fv_strobe vs model", int'(fv_strobe), int'(m_str));
         check(cfg_bad == m_bad, cur_req, "cfg_bad vs model", int'(cfg_bad), int'(m_bad));
      end
      if (cycles > 100000) begin
         errors++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 100000);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic set_vals(input int n, input int a);
      n_value = NW'(n);
      a_value = AW'(a);
   endtask

   // Count one whole cycle with continuous pulses: low and high pulse counts.
   task automatic count_cycle(input int en, input int ea, input string req);
      int lo = 0;
      int hi = 0;
      int guard = 0;
      pulse_en = 1'b1;
      do begin
         @(negedge clk);
         guard++;
      end while (!fv_strobe && guard < 3000);
      forever begin
         if (mod_ctl) hi++; else lo++;
         @(negedge clk);
         guard++;
         if (fv_strobe || guard > 6000) break;
      end
      check(lo == ea, req, "pulses with mod_ctl low", lo, ea);
      check(hi == en - ea, req, "pulses with mod_ctl high", hi, en - ea);
   endtask

   initial begin
      int n_clk;
      int cnt;
      bit mc_hold;
      bit any_str;

      // R1: reset state
      set_vals(5, 2);
      repeat (3) @(negedge clk);
      check(mod_ctl == 1'b0, "R1", "mod_ctl in reset", int'(mod_ctl), 0);
      check(fv_strobe == 1'b0, "R1", "fv_strobe in reset", int'(fv_strobe), 0);
      check(cfg_bad == 1'b0, "R1", "cfg_bad in reset", int'(cfg_bad), 0);
      cmp_en = 1'b1;

      // R2: first clock loads, pulse ignored; strobe after N+1 clocks
      cur_req = "R2";
      rst_n = 1'b1;
      pulse_en = 1'b1;
      n_clk = 0;
      do begin
         @(negedge clk);
         n_clk++;
      end while (!fv_strobe && n_clk < 100);
      check(n_clk == 6, "R2", "clocks to first strobe", n_clk, 6);

      // R3 R4 R5 R6: steady operation
      cur_req = "R4";
      count_cycle(5, 2, "R3");
      count_cycle(5, 2, "R4");
      set_vals(9, 4);
      cur_req = "R6";
      count_cycle(9, 4, "R6");
      count_cycle(9, 4, "R5");

      // R7: change values mid-cycle
      cur_req = "R7";
      set_vals(6, 3);
      count_cycle(6, 3, "R7");
      cnt = 0;
      forever begin
         cnt++;
         if (cnt == 2) set_vals(4, 1);
         @(negedge clk);
         if (fv_strobe || cnt > 100) break;
      end
      check(cnt == 6, "R7", "cycle length after mid-cycle change", cnt, 6);
      count_cycle(4, 1, "R7");

      // R8: boundaries A = 0, A = N, N = 1
      cur_req = "R8";
      set_vals(3, 0);
      count_cycle(3, 0, "R8");
      count_cycle(3, 0, "R8");
      set_vals(4, 4);
      count_cycle(4, 4, "R8");
      count_cycle(4, 4, "R8");
      set_vals(1, 0);
      count_cycle(1, 0, "R8");
      count_cycle(1, 0, "R8");

      // R10: gapped pulses and an idle stretch
      cur_req = "R10";
      set_vals(5, 2);
      count_cycle(5, 2, "R10");
      for (int i = 0; i < 60; i++) begin
         pulse_en = (i % 3 != 1);
         @(negedge clk);
      end
      pulse_en = 1'b0;
      @(negedge clk);
      mc_hold = mod_ctl;
      any_str = 1'b0;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         if (mod_ctl != mc_hold) any_str = 1'b1;
         if (fv_strobe) any_str = 1'b1;
      end
      check(any_str == 1'b0, "R10", "activity while idle", int'(any_str), 0);

      // R9: configuration flag
      cur_req = "R9";
      set_vals(2, 3);
      repeat (2) @(negedge clk);
      check(cfg_bad == 1'b1, "R9", "cfg_bad with A > N", int'(cfg_bad), 1);
      set_vals(0, 0);
      repeat (2) @(negedge clk);
      check(cfg_bad == 1'b1, "R9", "cfg_bad with N = 0", int'(cfg_bad), 1);
      set_vals(5, 5);
      repeat (2) @(negedge clk);
      check(cfg_bad == 1'b0, "R9", "cfg_bad with A = N", int'(cfg_bad), 0);
      set_vals(7, 2);
      @(negedge clk);
      check(cfg_bad == 1'b0, "R9", "cfg_bad with valid pair", int'(cfg_bad), 0);
      count_cycle(7, 2, "R9");

      pulse_en = 1'b0;
      repeat (3) @(negedge clk);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule